// File: doc/BRIEF.md
# Atomic Snooping Bus Controller

This block is the central controller of a shared bus that connects several cache agents to one memory. Agents raise a request with a command, an address and (for write-backs) a data word. A round-robin arbiter picks one requester. The controller then places that command and address on the bus for one cycle, where every agent sees it. It waits a fixed snoop window and samples the snoop lines that all agents drive. It then completes the transaction with data from memory, from a cache that holds a dirty copy, or with no data at all.

A transaction runs to completion before any other agent is granted. The order of grants is therefore the single global order in which writes and invalidations become visible. For read-type commands, memory is asked for the block at once, as a speculative read. If a snooper reports a dirty copy, that cache's data is returned instead, and the controller tells memory to drop the read.

The controller assumes that memory takes longer than the snoop window to answer a read, and that agents hold their snoop lines steady through that window.

Top module: `snoop_bus_ctrl`

## Requirements
- R1: At most one grant line is high. A grant stays unchanged from the cycle after the request is taken until the cycle of its completion pulse, and it drops in the cycle after completion, so transactions never overlap.
- R2: Arbitration is round-robin. The agent after the most recent winner has highest priority, and after reset agent 0 has highest priority.
- R3: One cycle after a grant is taken, `bus_valid_o` is high for exactly one cycle, carrying the winner's command, address and index. Command codes: 0 = read-miss, 1 = write-miss, 2 = invalidate, 3 = write-back.
- R4: In the address cycle, `mem_rd_o` pulses for read-miss and write-miss. For a write-back, `mem_wr_o` pulses with the requester's data on `mem_wdata_o`. Invalidate touches memory in neither direction.
- R5: Snoop lines are OR-ed across all agents and sampled exactly `SNOOP_DLY` cycles after the address cycle. An invalidate or write-back completes in the next cycle, `SNOOP_DLY+1` cycles after the address cycle.
- R6: A read-miss or write-miss that samples a dirty line returns the data of the lowest-indexed dirty agent. It raises `rsrc_cache_o`, pulses `mem_abort_o` together with the completion pulse, and ignores any later memory response.
- R7: A read-miss or write-miss with no dirty line waits for `mem_rvalid_i` and returns `mem_rdata_i` with completion in the next cycle.
- R8: Invalidate and write-back ignore the dirty line. They never abort memory and return zero data with `rsrc_cache_o` low.
- R9: `rshared_o` reports, with the completion pulse, whether any shared line was high at the snoop sample.
- R10: In the cycle after reset is held, there is no grant, no bus cycle, no memory request and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_AGENTS | Request line per agent, held until its completion |
| req_cmd_i | input | 2*N_AGENTS | Command code per agent |
| req_addr_i | input | ADDR_W*N_AGENTS | Block address per agent |
| req_wdata_i | input | DATA_W*N_AGENTS | Write-back data per agent |
| gnt_o | output | N_AGENTS | One-hot grant, held for the whole transaction |
| bus_valid_o | output | 1 | Command/address broadcast strobe |
| bus_cmd_o | output | 2 | Broadcast command |
| bus_addr_o | output | ADDR_W | Broadcast address |
| bus_src_o | output | IDX_W | Index of the requesting agent |
| snp_shared_i | input | N_AGENTS | Shared snoop line per agent |
| snp_dirty_i | input | N_AGENTS | Dirty snoop line per agent |
| snp_data_i | input | DATA_W*N_AGENTS | Block data each agent supplies when dirty |
| mem_rd_o | output | 1 | Speculative memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_abort_o | output | 1 | Cancels the outstanding memory read |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |
| done_o | output | N_AGENTS | Completion pulse to the granted agent |
| rdata_o | output | DATA_W | Returned block data, valid with completion |
| rshared_o | output | 1 | Some other copy reported shared |
| rsrc_cache_o | output | 1 | Data came from a dirty cache |

## Verification
Single requests are tried with each command under clean, shared-only and dirty snoop patterns. These patterns separate memory-sourced data from cache-sourced data and show whether the abort is correctly limited to read-type commands. Several dirty agents at once test the lowest-index choice of supplier. Groups of simultaneous requests, starting from different last winners, show whether grant order follows the rotating priority and whether each broadcast carries the right agent's command and address.

// File: rtl/snoop_bus_pkg.sv
// Shared types for the snooping bus controller.
// Assumes a 2-bit command field that the agents decode.
package snoop_bus_pkg;

    typedef enum logic [1:0] {
        CMD_RD_MISS = 2'd0,
        CMD_WR_MISS = 2'd1,
        CMD_INVAL   = 2'd2,
        CMD_WRBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SNOOP,
        ST_MEMWAIT,
        ST_FINISH
    } bus_state_e;

    // True for commands that need the block's data
    function automatic logic cmd_needs_data(bus_cmd_e c);
        return (c == CMD_RD_MISS) || (c == CMD_WR_MISS);
    endfunction

endpackage

// File: rtl/sb_rr_arbiter.sv
// Round-robin arbiter. The priority pointer starts at agent 0 and moves
// to the agent after each winner when advance_i is high.
// Assumes N_AGENTS >= 2.
module sb_rr_arbiter #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] req_i,
    input  logic                advance_i,
    output logic [N_AGENTS-1:0] win_onehot_o,
    output logic [IDX_W-1:0]    win_idx_o,
    output logic                any_req_o
);

    logic [IDX_W-1:0] ptr_q;

    // Pick the first requester at or after the pointer
    always_comb begin
        logic found;
        found        = 1'b0;
        win_onehot_o = '0;
        win_idx_o    = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N_AGENTS;
            if (!found && req_i[idx]) begin
                found             = 1'b1;
                win_onehot_o[idx] = 1'b1;
                win_idx_o         = IDX_W'(idx);
            end
        end
        any_req_o = found;
    end

    // Move the pointer past the winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            if (int'(win_idx_o) == N_AGENTS - 1) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= win_idx_o + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/sb_snoop_collect.sv
// Combines the snoop lines of all agents as wired-OR and selects the
// block data of the lowest-indexed agent reporting a dirty copy.
module sb_snoop_collect #(
    parameter int N_AGENTS = 4,
    parameter int DATA_W   = 32
) (
    input  logic [N_AGENTS-1:0]        shared_i,
    input  logic [N_AGENTS-1:0]        dirty_i,
    input  logic [DATA_W*N_AGENTS-1:0] data_i,
    output logic                       any_shared_o,
    output logic                       any_dirty_o,
    output logic [DATA_W-1:0]          sup_data_o
);

    // Wired-OR of the snoop lines
    always_comb begin
        any_shared_o = |shared_i;
        any_dirty_o  = |dirty_i;
    end

    // Lowest dirty index wins: scan from the top down
    always_comb begin
        sup_data_o = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (dirty_i[i]) begin
                sup_data_o = data_i[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/sb_sequencer.sv
// Transaction sequencer: takes one grant at a time and walks it through the
// address cycle, the snoop window and the data phase. Then it pulses done
// and releases the bus.
// Assumes memory answers later than SNOOP_DLY cycles after the read request,
// and that snoop lines are stable across the window.
module sb_sequencer
    import snoop_bus_pkg::*;
#(
    parameter int N_AGENTS  = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int SNOOP_DLY = 2,
    localparam int IDX_W    = $clog2(N_AGENTS),
    localparam int CNT_W    = $clog2(SNOOP_DLY + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                any_req_i,
    input  logic [N_AGENTS-1:0] win_onehot_i,
    input  logic [IDX_W-1:0]    win_idx_i,
    input  logic [1:0]          win_cmd_i,
    input  logic [ADDR_W-1:0]   win_addr_i,
    input  logic [DATA_W-1:0]   win_wdata_i,
    input  logic                any_shared_i,
    input  logic                any_dirty_i,
    input  logic [DATA_W-1:0]   sup_data_i,
    input  logic                mem_rvalid_i,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                advance_o,
    output logic [N_AGENTS-1:0] gnt_o,
    output logic                bus_valid_o,
    output logic [1:0]          bus_cmd_o,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic [IDX_W-1:0]    bus_src_o,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic                mem_abort_o,
    output logic [N_AGENTS-1:0] done_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rshared_o,
    output logic                rsrc_cache_o
);

    bus_state_e          state_q;
    logic [N_AGENTS-1:0] gnt_q;
    bus_cmd_e            cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [IDX_W-1:0]    src_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                shared_q;
    logic                cache_q;
    logic                last_snoop;

    // Last cycle of the snoop window
    always_comb last_snoop = (cnt_q == CNT_W'(SNOOP_DLY - 1));

    // Main transaction state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            gnt_q    <= '0;
            cmd_q    <= CMD_RD_MISS;
            addr_q   <= '0;
            wdata_q  <= '0;
            src_q    <= '0;
            cnt_q    <= '0;
            rdata_q  <= '0;
            shared_q <= 1'b0;
            cache_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cache_q <= 1'b0;
                    if (any_req_i) begin
                        gnt_q   <= win_onehot_i;
                        cmd_q   <= bus_cmd_e'(win_cmd_i);
                        addr_q  <= win_addr_i;
                        wdata_q <= win_wdata_i;
                        src_q   <= win_idx_i;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    cnt_q   <= '0;
                    state_q <= ST_SNOOP;
                end
                ST_SNOOP: begin
                    if (last_snoop) begin
                        shared_q <= any_shared_i;
                        if (cmd_needs_data(cmd_q)) begin
                            if (any_dirty_i) begin
                                rdata_q <= sup_data_i;
                                cache_q <= 1'b1;
                                state_q <= ST_FINISH;
                            end else begin
                                state_q <= ST_MEMWAIT;
                            end
                        end else begin
                            rdata_q <= '0;
                            cache_q <= 1'b0;
                            state_q <= ST_FINISH;
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_MEMWAIT: begin
                    if (mem_rvalid_i) begin
                        rdata_q <= mem_rdata_i;
                        state_q <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    gnt_q   <= '0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the held transaction
    always_comb begin
        advance_o    = (state_q == ST_IDLE) && any_req_i;
        gnt_o        = gnt_q;
        bus_valid_o  = (state_q == ST_ADDR);
        bus_cmd_o    = cmd_q;
        bus_addr_o   = addr_q;
        bus_src_o    = src_q;
        mem_rd_o     = (state_q == ST_ADDR) && cmd_needs_data(cmd_q);
        mem_wr_o     = (state_q == ST_ADDR) && (cmd_q == CMD_WRBACK);
        mem_wdata_o  = wdata_q;
        mem_abort_o  = (state_q == ST_FINISH) && cache_q;
        done_o       = (state_q == ST_FINISH) ? gnt_q : '0;
        rdata_o      = rdata_q;
        rshared_o    = shared_q;
        rsrc_cache_o = cache_q;
    end

endmodule

// File: rtl/snoop_bus_ctrl.sv
// Top of the atomic snooping bus controller: arbiter, request mux, snoop
// collector and transaction sequencer. One transaction at a time.
// Assumes requesters hold req and their fields until done.
module snoop_bus_ctrl #(
    parameter int N_AGENTS  = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int SNOOP_DLY = 2,
    localparam int IDX_W    = $clog2(N_AGENTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_AGENTS-1:0]        req_i,
    input  logic [2*N_AGENTS-1:0]      req_cmd_i,
    input  logic [ADDR_W*N_AGENTS-1:0] req_addr_i,
    input  logic [DATA_W*N_AGENTS-1:0] req_wdata_i,
    output logic [N_AGENTS-1:0]        gnt_o,
    output logic                       bus_valid_o,
    output logic [1:0]                 bus_cmd_o,
    output logic [ADDR_W-1:0]          bus_addr_o,
    output logic [IDX_W-1:0]           bus_src_o,
    input  logic [N_AGENTS-1:0]        snp_shared_i,
    input  logic [N_AGENTS-1:0]        snp_dirty_i,
    input  logic [DATA_W*N_AGENTS-1:0] snp_data_i,
    output logic                       mem_rd_o,
    output logic                       mem_wr_o,
    output logic [ADDR_W-1:0]          mem_addr_o,
    output logic [DATA_W-1:0]          mem_wdata_o,
    output logic                       mem_abort_o,
    input  logic                       mem_rvalid_i,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    output logic [N_AGENTS-1:0]        done_o,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       rshared_o,
    output logic                       rsrc_cache_o
);

    logic [N_AGENTS-1:0] win_onehot;
    logic [IDX_W-1:0]    win_idx;
    logic                any_req;
    logic                advance;
    logic [1:0]          win_cmd;
    logic [ADDR_W-1:0]   win_addr;
    logic [DATA_W-1:0]   win_wdata;
    logic                any_shared;
    logic                any_dirty;
    logic [DATA_W-1:0]   sup_data;

    sb_rr_arbiter #(.N_AGENTS(N_AGENTS)) arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .advance_i    (advance),
        .win_onehot_o (win_onehot),
        .win_idx_o    (win_idx),
        .any_req_o    (any_req)
    );

    // Select the winner's request fields
    always_comb begin
        win_cmd   = '0;
        win_addr  = '0;
        win_wdata = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (int'(win_idx) == i) begin
                win_cmd   = req_cmd_i[i*2 +: 2];
                win_addr  = req_addr_i[i*ADDR_W +: ADDR_W];
                win_wdata = req_wdata_i[i*DATA_W +: DATA_W];
            end
        end
    end

    sb_snoop_collect #(.N_AGENTS(N_AGENTS), .DATA_W(DATA_W)) snp_i (
        .shared_i     (snp_shared_i),
        .dirty_i      (snp_dirty_i),
        .data_i       (snp_data_i),
        .any_shared_o (any_shared),
        .any_dirty_o  (any_dirty),
        .sup_data_o   (sup_data)
    );

    sb_sequencer #(
        .N_AGENTS  (N_AGENTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SNOOP_DLY (SNOOP_DLY)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_req_i    (any_req),
        .win_onehot_i (win_onehot),
        .win_idx_i    (win_idx),
        .win_cmd_i    (win_cmd),
        .win_addr_i   (win_addr),
        .win_wdata_i  (win_wdata),
        .any_shared_i (any_shared),
        .any_dirty_i  (any_dirty),
        .sup_data_i   (sup_data),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .advance_o    (advance),
        .gnt_o        (gnt_o),
        .bus_valid_o  (bus_valid_o),
        .bus_cmd_o    (bus_cmd_o),
        .bus_addr_o   (bus_addr_o),
        .bus_src_o    (bus_src_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_abort_o  (mem_abort_o),
        .done_o       (done_o),
        .rdata_o      (rdata_o),
        .rshared_o    (rshared_o),
        .rsrc_cache_o (rsrc_cache_o)
    );

    // Memory address follows the broadcast address
    always_comb mem_addr_o = bus_addr_o;

endmodule

// File: rtl/snoop_bus_ctrl_chk.sv
// Protocol checker for the snooping bus controller, attached by bind.
// Tracks the snoop window with a counter rather than a deep delay.
module snoop_bus_ctrl_chk #(
    parameter int N_AGENTS  = 4,
    parameter int SNOOP_DLY = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_AGENTS-1:0] gnt_o,
    input logic                bus_valid_o,
    input logic [1:0]          bus_cmd_o,
    input logic                mem_rd_o,
    input logic                mem_wr_o,
    input logic                mem_abort_o,
    input logic [N_AGENTS-1:0] done_o
);

    logic [15:0] since_addr_q;
    logic        rd_type;

    always_comb rd_type = (bus_cmd_o == 2'd0) || (bus_cmd_o == 2'd1);

    // Count cycles since the address cycle of the current transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_addr_q <= '0;
        end else if (bus_valid_o) begin
            since_addr_q <= 16'd1;
        end else if (|done_o) begin
            since_addr_q <= '0;
        end else if (since_addr_q != 16'd0 && since_addr_q != 16'hFFFF) begin
            since_addr_q <= since_addr_q + 16'd1;
        end
    end

    p_gnt_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_gnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o && !(|done_o)) |=> (gnt_o == $past(gnt_o)));

    p_release_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_o) |=> (gnt_o == '0));

    p_single_addr_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |=> !bus_valid_o);

    p_valid_has_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (|gnt_o));

    p_mem_in_addr_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> bus_valid_o);

    p_snoop_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done_o) && !rd_type) |-> (since_addr_q == 16'(SNOOP_DLY + 1)));

    p_abort_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort_o |-> ((|done_o) && rd_type));

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (gnt_o == '0 && !bus_valid_o && !mem_rd_o && !mem_wr_o && done_o == '0));

endmodule

bind snoop_bus_ctrl snoop_bus_ctrl_chk #(
    .N_AGENTS  (N_AGENTS),
    .SNOOP_DLY (SNOOP_DLY)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_o       (gnt_o),
    .bus_valid_o (bus_valid_o),
    .bus_cmd_o   (bus_cmd_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_abort_o (mem_abort_o),
    .done_o      (done_o)
);

// File: tb/snoop_bus_ctrl_tb_top.sv
// Scoreboard bench: driver tasks push expected transactions, a monitor
// checks each broadcast and each completion against the queue head.
module snoop_bus_ctrl_tb_top;

    localparam int N  = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SD = 2;
    localparam int MEM_LAT = 5;

    typedef struct {
        int          src;
        logic [1:0]  cmd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic        shared;
        logic        cache;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_r = '0;
    logic [2*N-1:0]  req_cmd = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    snp_shared = '0;
    logic [N-1:0]    snp_dirty = '0;
    logic [DW*N-1:0] snp_data;
    logic            mem_rvalid = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;

    logic [N-1:0]    gnt_o;
    logic            bus_valid_o;
    logic [1:0]      bus_cmd_o;
    logic [AW-1:0]   bus_addr_o;
    logic [1:0]      bus_src_o;
    logic            mem_rd_o, mem_wr_o, mem_abort_o;
    logic [AW-1:0]   mem_addr_o;
    logic [DW-1:0]   mem_wdata_o;
    logic [N-1:0]    done_o;
    logic [DW-1:0]   rdata_o;
    logic            rshared_o, rsrc_cache_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int vcyc = 0;
    int last_win = N - 1;
    int mem_cnt = 0;
    logic [AW-1:0] mem_a = '0;
    bit chk_release = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    snoop_bus_ctrl #(.N_AGENTS(N), .ADDR_W(AW), .DATA_W(DW), .SNOOP_DLY(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_r), .req_cmd_i(req_cmd),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .gnt_o(gnt_o),
        .bus_valid_o(bus_valid_o), .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
        .bus_src_o(bus_src_o), .snp_shared_i(snp_shared), .snp_dirty_i(snp_dirty),
        .snp_data_i(snp_data), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_abort_o(mem_abort_o),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done_o),
        .rdata_o(rdata_o), .rshared_o(rshared_o), .rsrc_cache_o(rsrc_cache_o)
    );

    function automatic logic [DW-1:0] mem_fn(logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    function automatic logic [DW-1:0] cache_fn(int i);
        return {16'hCAFE, 8'(i), 8'h3C};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) snp_data[i*DW +: DW] = cache_fn(i);
    end

    task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model and monitor
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mem_abort_o) begin
            mem_cnt = 0;
        end else if (mem_rd_o) begin
            mem_cnt = MEM_LAT;
            mem_a   = mem_addr_o;
        end else if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_fn(mem_a);
            end
        end

        if (rst_n && bus_valid_o) begin
            if (q.size() == 0) begin
                check(0, "R3", "unexpected bus cycle", 64'(bus_addr_o), 0);
            end else begin
                exp_t e;
                e = q[0];
                vcyc = cyc;
                check(bus_cmd_o == e.cmd, "R3", "bus cmd", 64'(bus_cmd_o), 64'(e.cmd));
                check(bus_addr_o == e.addr, "R3", "bus addr", 64'(bus_addr_o), 64'(e.addr));
                check(int'(bus_src_o) == e.src, "R2", "grant order (src)", 64'(bus_src_o), 64'(e.src));
                check(gnt_o == N'(1 << e.src), "R1", "grant one-hot", 64'(gnt_o), 64'(1 << e.src));
                check(mem_rd_o == (e.cmd < 2), "R4", "speculative mem read", 64'(mem_rd_o), 64'(e.cmd < 2));
                check(mem_wr_o == (e.cmd == 3), "R4", "mem write", 64'(mem_wr_o), 64'(e.cmd == 3));
                if (e.cmd == 3)
                    check(mem_wdata_o == e.wdata, "R4", "mem wdata", 64'(mem_wdata_o), 64'(e.wdata));
            end
        end

        if (rst_n && (|done_o)) begin
            if (q.size() == 0) begin
                check(0, "R1", "unexpected done", 64'(done_o), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(done_o == N'(1 << e.src), "R1", "done target", 64'(done_o), 64'(1 << e.src));
                check(rdata_o == e.rdata, e.cache ? "R6" : (e.cmd < 2 ? "R7" : "R8"),
                      "rdata", 64'(rdata_o), 64'(e.rdata));
                check(rshared_o == e.shared, "R9", "shared result", 64'(rshared_o), 64'(e.shared));
                check(rsrc_cache_o == e.cache, "R6", "cache source flag", 64'(rsrc_cache_o), 64'(e.cache));
                check(mem_abort_o == e.cache, e.cmd < 2 ? "R6" : "R8", "mem abort",
                      64'(mem_abort_o), 64'(e.cache));
                if (e.cmd >= 2)
                    check(cyc - vcyc == SD + 1, "R5", "snoop window length", 64'(cyc - vcyc), 64'(SD + 1));
                req_r[e.src] = 1'b0;
                chk_release = 1;
            end
        end else if (chk_release) begin
            chk_release = 0;
            check(gnt_o == '0, "R1", "grant released", 64'(gnt_o), 0);
        end
    end

    task automatic set_req(int a, logic [1:0] c, logic [AW-1:0] ad);
        req_cmd[a*2 +: 2]    = c;
        req_addr[a*AW +: AW] = ad;
        req_wdata[a*DW +: DW] = {16'hBEEF, ad};
    endtask

    function automatic exp_t make_exp(int a, logic [1:0] c, logic [AW-1:0] ad);
        exp_t e;
        e.src    = a;
        e.cmd    = c;
        e.addr   = ad;
        e.wdata  = {16'hBEEF, ad};
        e.shared = |snp_shared;
        e.cache  = (c < 2) && (|snp_dirty);
        if (c >= 2) begin
            e.rdata = '0;
        end else if (e.cache) begin
            e.rdata = '0;
            for (int i = N - 1; i >= 0; i--)
                if (snp_dirty[i]) e.rdata = cache_fn(i);
        end else begin
            e.rdata = mem_fn(ad);
        end
        return e;
    endfunction

    task automatic run_one(int a, logic [1:0] c, logic [AW-1:0] ad,
                           logic [N-1:0] shm, logic [N-1:0] dm);
        snp_shared = shm;
        snp_dirty  = dm;
        set_req(a, c, ad);
        q.push_back(make_exp(a, c, ad));
        req_r[a] = 1'b1;
        last_win = a;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // All agents in the mask request at once; expected order is round-robin
    task automatic run_group(logic [N-1:0] mask, logic [1:0] c, logic [AW-1:0] base);
        int first;
        snp_shared = '0;
        snp_dirty  = '0;
        first = last_win;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (first + k) % N;
            if (mask[idx]) begin
                set_req(idx, c, base + AW'(idx * 16));
                q.push_back(make_exp(idx, c, base + AW'(idx * 16)));
                last_win = idx;
            end
        end
        req_r = req_r | mask;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: quiet while reset is held
        check(gnt_o == '0 && !bus_valid_o && !mem_rd_o && !mem_wr_o && done_o == '0,
              "R10", "reset state", 64'({gnt_o, bus_valid_o, mem_rd_o, mem_wr_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_one(2, 2'd0, 16'h0100, 4'b0000, 4'b0000);   // R7 clean read
        run_one(0, 2'd0, 16'h0200, 4'b0010, 4'b1010);   // R6 lowest dirty = 1
        run_one(2, 2'd1, 16'h0300, 4'b0000, 4'b1000);   // R6 write-miss dirty
        run_one(1, 2'd1, 16'h0400, 4'b0100, 4'b0000);   // R9 shared, clean
        run_one(3, 2'd2, 16'h0500, 4'b0001, 4'b0001);   // R8 invalidate ignores dirty
        run_one(0, 2'd3, 16'h0600, 4'b0000, 4'b0100);   // R8 write-back ignores dirty
        run_group(4'b1111, 2'd0, 16'h1000);             // R2 full rotation
        run_group(4'b1010, 2'd1, 16'h2000);             // R2 partial mask
        run_one(2, 2'd0, 16'h0700, 4'b0000, 4'b0000);
        run_group(4'b1111, 2'd2, 16'h3000);             // R2 from last winner 2
        run_group(4'b0101, 2'd3, 16'h4000);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule